// File: doc/BRIEF.md
# Bit-Error Loss-of-Signal Detector

This block watches a stream of single-cycle bit-error pulses and decides whether the incoming signal is lost. A saturating counter adds up the error pulses that arrive within a measurement interval. The interval is a fixed number of reference ticks, where each tick is a one-cycle strobe derived from the reference clock. At the end of each interval the counter is cleared. If the running count reaches an upper threshold at any point, the loss flag is raised on the next clock edge. The block does not wait for the interval to end.

Clearing the flag is deliberately slower. At each interval boundary the block records a pass bit, which says whether that interval's final count stayed below a lower threshold. The pass bit is pushed into a short chain of reset-able registers. The flag drops only once every stage of the chain holds a pass. Because the two thresholds differ, a count that lands between them neither raises nor clears the flag. The block exposes the loss flag, the latest pass bit and the all-stages-pass qualifier.

Top module: `los_detector`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `los` is 1, `ok` is 0 and `nolos` is 0. The qualifier chain is cleared, so release needs a full run of `QUAL_STAGES` passing intervals.
- R2: When an error pulse brings the count of the current interval to `HI_THRESH` or above, `los` is 1 on the cycle after that pulse. This holds mid-interval and also on the boundary cycle.
- R3: An interval boundary is a cycle with `ref_tick` high that completes `INTERVAL` ticks. On the cycle after a boundary, `ok` is 1 exactly when that interval's final count is below `LO_THRESH`, and 0 otherwise. The final count includes an error pulse on the boundary cycle itself.
- R4: `nolos` is 1 exactly when the last `QUAL_STAGES` boundaries all recorded a pass. `los` falls on the clock edge after a cycle in which `nolos` is 1, unless R2 raises it on that same edge. `los` never falls otherwise.
- R5: An interval whose final count is at least `LO_THRESH` and below `HI_THRESH` leaves `los` unchanged, whether it was 0 or 1. Such an interval records a fail (`ok`=0) and so clears `nolos`.
- R6: The error count saturates at 2^`CNT_W`-1 and does not wrap. With `CNT_W`=4, an interval with 20 error pulses therefore ends with `ok`=0.
- R7: Cycles with `ref_tick` low do not advance the interval. The first boundary after reset falls on the `INTERVAL`-th cycle with `ref_tick` high.
- R8: The block refuses to elaborate unless 1 <= `LO_THRESH` < `HI_THRESH` <= 2^`CNT_W`-1 and `INTERVAL` >= 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference-domain clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| err_pulse | input | 1 | One count per cycle in which it is high |
| ref_tick | input | 1 | Reference tick strobe that advances the interval timer |
| los | output | 1 | Loss-of-signal flag |
| ok | output | 1 | Pass bit of the most recent completed interval |
| nolos | output | 1 | All qualifier stages hold a pass |

## Verification
Every result is registered, so each one is due a fixed number of edges after the stimulus that causes it:

- `los` rises one edge after the pulse that reaches the upper threshold.
- `ok` and `nolos` change one edge after a boundary.
- `los` falls one edge after that, so two edges after the third passing boundary.

The bench drives inputs on the falling edge and keeps a cycle-accurate model, built from these rules, that it advances on each rising edge. It compares all three outputs at every falling edge, so each output is judged exactly one edge after its cause. The directed checks count edges from the release of reset, and from a boundary the model has just seen, to hit these exact cycles.

// File: rtl/los_det_pkg.sv
package los_det_pkg;

    // Link condition held by the loss flag register.
    typedef enum logic {
        LINK_GOOD = 1'b0,
        LINK_LOST = 1'b1
    } link_state_e;

    // Per-cycle view of the error counter handed to the rest of the block.
    typedef struct packed {
        logic boundary;   // this cycle closes an interval
        logic reach_hi;   // count including this cycle is at/above upper threshold
        logic below_lo;   // count including this cycle is below lower threshold
    } cnt_view_t;

    // Outputs grouped as one status word.
    typedef struct packed {
        logic los;
        logic ok;
        logic nolos;
    } los_status_t;

    // Saturating increment on a 32-bit carrier; callers truncate.
    function automatic logic [31:0] sat_step(input logic [31:0] value,
                                             input logic        inc,
                                             input logic [31:0] ceiling);
        if (inc && (value < ceiling))
            return value + 32'd1;
        return value;
    endfunction

    // Compile-time legality of the threshold set (R8).
    function automatic bit cfg_legal(input int lo, input int hi,
                                     input int cnt_w, input int interval);
        return (lo >= 1) && (lo < hi) && (hi <= (1 << cnt_w) - 1) && (interval >= 2);
    endfunction

endpackage

// File: rtl/los_interval_timer.sv
module los_interval_timer
    import los_det_pkg::*;
#(
    parameter int INTERVAL = 65536
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_tick,
    output logic boundary
);
    localparam int TMR_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [TMR_W-1:0] LAST = TMR_W'(INTERVAL - 1);

    logic [TMR_W-1:0] tick_cnt;

    assign boundary = ref_tick && (tick_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst)
            tick_cnt <= '0;
        else if (ref_tick)
            tick_cnt <= (tick_cnt == LAST) ? '0 : tick_cnt + 1'b1;
    end

    // R7: without a reference tick the interval position does not move.
    p_timer_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !ref_tick |=> $stable(tick_cnt));

    // R7: a boundary always restarts the interval from zero.
    p_timer_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        boundary |=> (tick_cnt == '0));

endmodule

// File: rtl/los_err_counter.sv
module los_err_counter
    import los_det_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int HI_THRESH = 128,
    parameter int LO_THRESH = 65
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      err_pulse,
    input  logic      boundary,
    output cnt_view_t view
);
    localparam logic [CNT_W-1:0] CEIL = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] HI_C = CNT_W'(HI_THRESH);
    localparam logic [CNT_W-1:0] LO_C = CNT_W'(LO_THRESH);

    logic [CNT_W-1:0] err_cnt;
    logic [CNT_W-1:0] cnt_nxt;

    // Count including any pulse present in this cycle.
    assign cnt_nxt = CNT_W'(sat_step(32'(err_cnt), err_pulse, 32'(CEIL)));

    assign view.boundary = boundary;
    assign view.reach_hi = (cnt_nxt >= HI_C);
    assign view.below_lo = (cnt_nxt < LO_C);

    always_ff @(posedge clk) begin
        if (rst || boundary)
            err_cnt <= '0;
        else
            err_cnt <= cnt_nxt;
    end

    // R6: within an interval the count never goes down.
    p_no_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        !boundary |=> (err_cnt >= $past(err_cnt)));

    // R6: a full counter stays full until the interval ends.
    p_sat_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (err_cnt == CEIL) && !boundary |=> (err_cnt == CEIL));

endmodule

// File: rtl/los_release_qual.sv
module los_release_qual
    import los_det_pkg::*;
#(
    parameter int QUAL_STAGES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic boundary,
    input  logic pass_in,
    output logic ok,
    output logic nolos
);
    logic [QUAL_STAGES-1:0] stage;

    // Stage 0 takes the newest pass bit; each later stage takes its neighbour.
    for (genvar i = 0; i < QUAL_STAGES; i++) begin : g_stage
        logic d_in;
        if (i == 0) begin : g_head
            assign d_in = pass_in;
        end else begin : g_tail
            assign d_in = stage[i-1];
        end

        always_ff @(posedge clk) begin
            if (rst)
                stage[i] <= 1'b0;
            else if (boundary)
                stage[i] <= d_in;
        end
    end

    assign ok    = stage[0];
    assign nolos = &stage;

    // R3: the newest stage captures the pass bit at each boundary.
    p_capture_r3: assert property (@(posedge clk) disable iff (rst)
        boundary |=> (ok == $past(pass_in)));

    // R4: the chain only moves at a boundary.
    p_chain_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !boundary |=> $stable(stage));

    // R4: a full qualifier implies the newest interval passed.
    p_nolos_ok_r4: assert property (@(posedge clk) disable iff (rst)
        nolos |-> ok);

endmodule

// File: rtl/los_detector.sv
module los_detector
    import los_det_pkg::*;
#(
    parameter int INTERVAL    = 65536,
    parameter int CNT_W       = 8,
    parameter int HI_THRESH   = 128,
    parameter int LO_THRESH   = 65,
    parameter int QUAL_STAGES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic err_pulse,
    input  logic ref_tick,
    output logic los,
    output logic ok,
    output logic nolos
);
    // R8: reject threshold sets without hysteresis or out of counter range.
    if (!cfg_legal(LO_THRESH, HI_THRESH, CNT_W, INTERVAL)) begin : g_bad_cfg
        initial $fatal(1, "los_detector: need 1 <= LO_THRESH < HI_THRESH <= 2**CNT_W-1, INTERVAL >= 2");
    end

    logic        boundary;
    cnt_view_t   view;
    logic        q_ok;
    logic        q_nolos;
    link_state_e link_q;
    link_state_e link_d;
    los_status_t status;

    los_interval_timer #(
        .INTERVAL (INTERVAL)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .ref_tick (ref_tick),
        .boundary (boundary)
    );

    los_err_counter #(
        .CNT_W     (CNT_W),
        .HI_THRESH (HI_THRESH),
        .LO_THRESH (LO_THRESH)
    ) u_count (
        .clk       (clk),
        .rst       (rst),
        .err_pulse (err_pulse),
        .boundary  (boundary),
        .view      (view)
    );

    los_release_qual #(
        .QUAL_STAGES (QUAL_STAGES)
    ) u_qual (
        .clk      (clk),
        .rst      (rst),
        .boundary (view.boundary),
        .pass_in  (view.below_lo),
        .ok       (q_ok),
        .nolos    (q_nolos)
    );

    // Raising wins over releasing; release needs a full qualifier.
    always_comb begin
        link_d = link_q;
        if (view.reach_hi)
            link_d = LINK_LOST;
        else if (q_nolos)
            link_d = LINK_GOOD;
    end

    always_ff @(posedge clk) begin
        if (rst)
            link_q <= LINK_LOST;
        else
            link_q <= link_d;
    end

    assign status.los   = (link_q == LINK_LOST);
    assign status.ok    = q_ok;
    assign status.nolos = q_nolos;

    assign los   = status.los;
    assign ok    = status.ok;
    assign nolos = status.nolos;

    // R2: reaching the upper threshold raises the flag on the next edge.
    p_raise_r2: assert property (@(posedge clk) disable iff (rst)
        view.reach_hi |=> los);

    // R4: the flag falls only after a full qualifier.
    p_release_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(los) |-> $past(q_nolos));

    // R5: an unqualified, below-upper cycle keeps a raised flag raised.
    p_hold_lost_r5: assert property (@(posedge clk) disable iff (rst)
        los && !q_nolos |=> los);

    // R5: a clear flag stays clear unless the upper threshold is reached.
    p_hold_good_r5: assert property (@(posedge clk) disable iff (rst)
        !los && !view.reach_hi |=> !los);

endmodule

// File: tb/los_detector_bench.sv
module los_detector_bench;
    localparam int INTERVAL = 32;
    localparam int CNT_W    = 4;
    localparam int HI       = 12;
    localparam int LO       = 6;
    localparam int STAGES   = 3;
    localparam int CEIL     = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic err_pulse = 1'b0;
    logic ref_tick = 1'b0;
    logic los, ok, nolos;

    int n_checks = 0;
    int n_fail   = 0;
    bit wd_hit   = 0;

    // Model state, built from the requirements.
    int              m_tcnt = 0;
    int              m_cnt  = 0;
    logic [STAGES-1:0] m_q  = '0;
    logic            m_los  = 1'b1;
    bit              m_bnd  = 0;   // boundary seen on the last edge

    always #4 clk = ~clk;   // 125 MHz

    los_detector #(
        .INTERVAL    (INTERVAL),
        .CNT_W       (CNT_W),
        .HI_THRESH   (HI),
        .LO_THRESH   (LO),
        .QUAL_STAGES (STAGES)
    ) u_los_detector (
        .clk       (clk),
        .rst       (rst),
        .err_pulse (err_pulse),
        .ref_tick  (ref_tick),
        .los       (los),
        .ok        (ok),
        .nolos     (nolos)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_tcnt = 0; m_cnt = 0; m_q = '0; m_los = 1'b1; m_bnd = 0;
        end else begin
            int  nxt;
            bit  bnd;
            nxt = (err_pulse && m_cnt < CEIL) ? m_cnt + 1 : m_cnt;   // R6
            bnd = ref_tick && (m_tcnt == INTERVAL - 1);               // R7
            if (nxt >= HI) m_los = 1'b1;                              // R2
            else if (&m_q) m_los = 1'b0;                              // R4
            if (bnd) begin
                m_q   = {m_q[STAGES-2:0], (nxt < LO)};                // R3
                m_cnt = 0;
            end else begin
                m_cnt = nxt;
            end
            if (ref_tick) m_tcnt = bnd ? 0 : m_tcnt + 1;
            m_bnd = bnd;
        end
    end

    function automatic bit check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
            return 0;
        end
        return 1;
    endfunction

    // One clock: wait an edge, then compare every output with the model.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        void'(check("R2 los vs model", los, m_los));
        void'(check("R3 ok vs model", ok, m_q[0]));
        void'(check("R4 nolos vs model", nolos, &m_q));
    endtask

    task automatic wait_boundary();
        do step(); while (!m_bnd);
    endtask

    task automatic run_main();
        void'($urandom(32'd20240611));
        // R1: reset state.
        repeat (3) @(negedge clk);
        void'(check("R1 los in reset", los, 1'b1));
        void'(check("R1 ok in reset", ok, 1'b0));
        void'(check("R1 nolos in reset", nolos, 1'b0));
        ref_tick = 1'b1;
        rst = 1'b0;
        step();
        void'(check("R1 los after reset", los, 1'b1));
        void'(check("R1 nolos after reset", nolos, 1'b0));
        // R7/R4: quiet link, boundaries at edges 32, 64, 96.
        repeat (3 * INTERVAL - 2) step();
        void'(check("R7 nolos before third boundary", nolos, 1'b0));
        step();
        void'(check("R4 nolos after third pass", nolos, 1'b1));
        void'(check("R4 los still held", los, 1'b1));
        step();
        void'(check("R4 los released", los, 1'b0));
        // R2: burst reaching HI mid-interval.
        err_pulse = 1'b1;
        repeat (HI - 1) step();
        void'(check("R2 los below HI", los, 1'b0));
        step();
        void'(check("R2 los at HI", los, 1'b1));
        err_pulse = 1'b0;
        // R6: 20 pulses in one interval must not wrap.
        wait_boundary();
        err_pulse = 1'b1;
        repeat (20) step();
        err_pulse = 1'b0;
        wait_boundary();
        void'(check("R6 saturated interval fails", ok, 1'b0));
        // R5: mid-band interval while lost keeps LOS.
        err_pulse = 1'b1;
        repeat (LO + 2) step();
        err_pulse = 1'b0;
        wait_boundary();
        void'(check("R5 mid-band ok", ok, 1'b0));
        void'(check("R5 lost stays lost", los, 1'b1));
        // Release again, then a mid-band interval while good.
        repeat (3) wait_boundary();
        step();
        void'(check("R4 los released again", los, 1'b0));
        err_pulse = 1'b1;
        repeat (LO + 2) step();
        err_pulse = 1'b0;
        wait_boundary();
        void'(check("R5 good stays good", los, 1'b0));
        void'(check("R5 mid-band clears nolos", nolos, 1'b0));
        // R7: ticks withheld, interval must not advance.
        ref_tick = 1'b0;
        repeat (3 * INTERVAL) step();
        void'(check("R7 no boundary without ticks", nolos, 1'b0));
        ref_tick = 1'b1;
        // Random intervals of varied error density and tick rate.
        for (int iv = 0; iv < 48; iv++) begin
            int dens = $urandom_range(0, 3);
            int trate = $urandom_range(2, 4);
            do begin
                ref_tick  = ($urandom_range(0, 3) < trate);
                case (dens)
                    0: err_pulse = 1'b0;
                    1: err_pulse = ($urandom_range(0, 31) < 3);
                    2: err_pulse = ($urandom_range(0, 31) < 8);
                    default: err_pulse = ($urandom_range(0, 31) < 20);
                endcase
                step();
            end while (!m_bnd);
        end
        err_pulse = 1'b0;
        ref_tick  = 1'b0;
    endtask

    initial begin
        fork
            run_main();
            begin
                repeat (150000) @(posedge clk);
                wd_hit = 1;
            end
        join_any
        disable fork;
        if (wd_hit) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
        end
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end

endmodule